// File: doc/BRIEF.md
# Double-Buffered Colour Matrix

This block converts the colour space of a pixel stream. Each pixel has three unsigned channels, and each output channel is an affine combination of them: three signed multiply coefficients plus one signed offset per output row. That is a 3x4 matrix in total. Two complete coefficient sets are stored, set A and set B, so software can prepare one set while the other one is in use.

A mode register chooses between pass-through, set A and set B. A new mode written by software is held as pending. It becomes active only at the next frame-start strobe, so a frame is never processed with two different matrices. The active mode is reported on a status output. Software reads this status to find the idle set, loads the idle set and then requests the switch. The hardware discards writes aimed at the set currently in use.

Each pixel travels through a two-stage pipeline with fixed latency, and its valid flag travels alongside it. Every pixel carries the mode that was active when it entered the pipeline, so a frame boundary never mixes settings inside one pixel.

Top module: `colour_matrix_pingpong`

## Requirements
- R1: After reset the status is 0 (pass-through), `pixOutValid` is low, all output channels are 0 and both coefficient sets hold zero.
- R2: In mode 0 each output channel equals the matching input channel unchanged, two clock cycles after the input.
- R3: The mode word is written at `cfgAddr` 4'hF, with the value in `cfgWrData[1:0]`. Value 1 applies set A and value 2 applies set B. A write of value 3 is discarded, and the status never shows 3.
- R4: At any other address, `cfgAddr[3]` chooses the set (0 = A, 1 = B) and `cfgAddr[2:0]` chooses a word from 0 to 5. Word k carries two coefficients: bits [15:0] and bits [31:16]. The coefficients in word order are C11 C12 / C13 C14 / C21 C22 / C23 C24 / C31 C32 / C33 C34. Word indices 6 and 7 store nothing.
- R5: A coefficient write aimed at the set that is currently active has no effect.
- R6: A mode write becomes pending. `activeMode` and the matrix used for new pixels change only at the clock edge where `frameStart` is high. A pixel that enters on that same edge still uses the previous setting.
- R7: Coefficients C11 to C33 (excluding the offset columns) are signed 2.13 values. The offsets C14, C24 and C34 are signed integers in output LSBs. Each output channel i is computed as follows: take Ci1*R + Ci2*G + Ci3*B, add Ci4*2^13, add 2^12, then shift arithmetically right by 13 (rounding half up).
- R8: A rounded result below 0 gives 0, and a result above 2^PIX_W-1 gives 2^PIX_W-1.
- R9: `pixOutValid` repeats `pixInValid` exactly two cycles later, for every cycle, including gaps in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration word address |
| cfgWrData | input | 32 | Configuration write data |
| frameStart | input | 1 | Frame boundary strobe; commits the pending mode |
| pixInValid | input | 1 | Input pixel valid |
| pixInR | input | PIX_W | Input red / Cr channel |
| pixInG | input | PIX_W | Input green / Y channel |
| pixInB | input | PIX_W | Input blue / Cb channel |
| pixOutValid | output | 1 | Output pixel valid |
| pixOutR | output | PIX_W | Output channel 1 |
| pixOutG | output | PIX_W | Output channel 2 |
| pixOutB | output | PIX_W | Output channel 3 |
| activeMode | output | 2 | Mode in use: 0 pass-through, 1 set A, 2 set B |

## Verification
Set A holds a pure channel rotation. Comparing its output with pass-through shows which set is live and whether the live set changes before the frame strobe. Set B holds fractional and negative coefficients with offsets. Pixels near zero test the half-up rounding, and full-scale pixels drive one row above the maximum and another below zero. A stream with a gap between two valid pixels separates the fixed latency from valid-flag forwarding. Writes aimed at the live set, to word indices 6 and 7, and of mode value 3 are each followed by a pixel or a status read that would reveal any leak.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int NUM_CH     = 3;
  localparam int NUM_COEF   = NUM_CH * (NUM_CH + 1);
  localparam int BANK_WORDS = NUM_COEF / 2;
  localparam int IDX_W      = $clog2(BANK_WORDS);
  localparam int CFG_ADDR_W = IDX_W + 1;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_BANK_A = 2'd1,
    MODE_BANK_B = 2'd2
  } csc_mode_e;

  typedef struct packed {
    logic [1:0]       bankWe;
    logic [IDX_W-1:0] wordIdx;
    logic             bypass;
    logic             useB;
  } csc_ctl_t;
endpackage

// File: rtl/csc_bank.sv
module csc_bank #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         we,
  input  logic [$clog2(WORDS)-1:0]     wordIdx,
  input  logic [WORD_W-1:0]            wrData,
  output logic [WORDS-1:0][WORD_W-1:0] words
);
  localparam int IW = $clog2(WORDS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      words <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (we && wordIdx == IW'(w)) words[w] <= wrData;
      end
    end
  end
endmodule

// File: rtl/csc_ctrl.sv
module csc_ctrl
  import csc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [1:0]            cfgModeBits,
  input  logic                  frameStart,
  output csc_ctl_t              ctl,
  output logic [1:0]            activeMode
);
  localparam logic [CFG_ADDR_W-1:0] MODE_ADDR = '1;

  csc_mode_e        pendingMode, liveMode;
  logic             modeWr, coefWr, bankSel;
  logic [IDX_W-1:0] wordIdx;

  assign wordIdx = cfgAddr[IDX_W-1:0];
  assign bankSel = cfgAddr[IDX_W];
  assign modeWr  = cfgWrEn && (cfgAddr == MODE_ADDR);
  assign coefWr  = cfgWrEn && !modeWr && (wordIdx < IDX_W'(BANK_WORDS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingMode <= MODE_BYPASS;
      liveMode    <= MODE_BYPASS;
    end else begin
      if (modeWr && cfgModeBits != 2'd3) pendingMode <= csc_mode_e'(cfgModeBits);
      if (frameStart) liveMode <= pendingMode;
    end
  end

  always_comb begin
    ctl.wordIdx   = wordIdx;
    ctl.bankWe[0] = coefWr && !bankSel && (liveMode != MODE_BANK_A);
    ctl.bankWe[1] = coefWr &&  bankSel && (liveMode != MODE_BANK_B);
    ctl.bypass    = (liveMode == MODE_BYPASS);
    ctl.useB      = (liveMode == MODE_BANK_B);
  end

  assign activeMode = liveMode;

  // R6: status moves only on a frame boundary
  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(activeMode));

  // R3: the reserved mode value never becomes active
  p_mode_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    activeMode != 2'd3);
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 13
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  csc_ctl_t                     ctl,
  input  logic [2*COEF_W-1:0]          cfgWrData,
  input  logic                         pixInValid,
  input  logic [NUM_CH-1:0][PIX_W-1:0] pixIn,
  output logic                         pixOutValid,
  output logic [NUM_CH-1:0][PIX_W-1:0] pixOut
);
  localparam int WORD_W = 2 * COEF_W;
  localparam int PROD_W = COEF_W + PIX_W + 1;
  localparam int ACC_W  = PROD_W + 3;
  localparam logic signed [ACC_W-1:0] ROUND_HALF = ACC_W'(64'd1 << (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] PIX_MAX    = ACC_W'((64'd1 << PIX_W) - 1);

  logic [1:0][BANK_WORDS-1:0][WORD_W-1:0] bankWords;
  logic [BANK_WORDS-1:0][WORD_W-1:0]      liveWords;
  logic signed [COEF_W-1:0]               coef [NUM_COEF];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    csc_bank #(.WORD_W(WORD_W), .WORDS(BANK_WORDS)) u_bank (
      .clk     (clk),
      .rstN    (rstN),
      .we      (ctl.bankWe[b]),
      .wordIdx (ctl.wordIdx),
      .wrData  (cfgWrData),
      .words   (bankWords[b])
    );
  end

  assign liveWords = bankWords[ctl.useB];

  always_comb begin
    for (int k = 0; k < NUM_COEF; k++)
      coef[k] = liveWords[k / 2][(k % 2) * COEF_W +: COEF_W];
  end

  // stage 1: products
  logic signed [PROD_W-1:0] prodD [NUM_CH][NUM_CH];
  logic signed [PROD_W-1:0] prodQ [NUM_CH][NUM_CH];
  logic signed [COEF_W-1:0] offQ  [NUM_CH];
  logic                     s1Valid, s1Bypass;
  logic [NUM_CH-1:0][PIX_W-1:0] s1Pix;

  always_comb begin
    for (int r = 0; r < NUM_CH; r++)
      for (int c = 0; c < NUM_CH; c++)
        prodD[r][c] = PROD_W'(coef[r * (NUM_CH + 1) + c]) * PROD_W'($signed({1'b0, pixIn[c]}));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Bypass <= 1'b1;
      s1Pix    <= '0;
      for (int r = 0; r < NUM_CH; r++) begin
        offQ[r] <= '0;
        for (int c = 0; c < NUM_CH; c++) prodQ[r][c] <= '0;
      end
    end else begin
      s1Valid  <= pixInValid;
      s1Bypass <= ctl.bypass;
      s1Pix    <= pixIn;
      for (int r = 0; r < NUM_CH; r++) begin
        offQ[r] <= coef[r * (NUM_CH + 1) + NUM_CH];
        for (int c = 0; c < NUM_CH; c++) prodQ[r][c] <= prodD[r][c];
      end
    end
  end

  // stage 2: sum, round, saturate
  logic [NUM_CH-1:0][PIX_W-1:0] matD;
  always_comb begin
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] scaled;
    for (int r = 0; r < NUM_CH; r++) begin
      acc = ROUND_HALF + (ACC_W'(offQ[r]) <<< FRAC_W);
      for (int c = 0; c < NUM_CH; c++) acc = acc + ACC_W'(prodQ[r][c]);
      scaled = acc >>> FRAC_W;
      if (scaled < 0)            matD[r] = '0;
      else if (scaled > PIX_MAX) matD[r] = {PIX_W{1'b1}};
      else                       matD[r] = scaled[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixOutValid <= 1'b0;
      pixOut      <= '0;
    end else begin
      pixOutValid <= s1Valid;
      pixOut      <= s1Bypass ? s1Pix : matD;
    end
  end

  // R9: valid flag follows input with a fixed two-cycle delay
  p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    pixInValid |-> ##2 pixOutValid);
  p_gap_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    !pixInValid |-> ##2 !pixOutValid);

  // R2: pass-through pixels leave unchanged
  p_bypass_same_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pixInValid && ctl.bypass) |-> ##2 (pixOut == $past(pixIn, 2)));

  // R5: the set in use is never overwritten
  p_live_a_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.bypass && !ctl.useB) |=> $stable(bankWords[0]));
  p_live_b_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.useB |=> $stable(bankWords[1]));
endmodule

// File: rtl/colour_matrix_pingpong.sv
module colour_matrix_pingpong
  import csc_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 13
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [2*COEF_W-1:0]   cfgWrData,
  input  logic                  frameStart,
  input  logic                  pixInValid,
  input  logic [PIX_W-1:0]      pixInR,
  input  logic [PIX_W-1:0]      pixInG,
  input  logic [PIX_W-1:0]      pixInB,
  output logic                  pixOutValid,
  output logic [PIX_W-1:0]      pixOutR,
  output logic [PIX_W-1:0]      pixOutG,
  output logic [PIX_W-1:0]      pixOutB,
  output logic [1:0]            activeMode
);
  csc_ctl_t                     ctl;
  logic [NUM_CH-1:0][PIX_W-1:0] pixInBus, pixOutBus;

  assign pixInBus = {pixInB, pixInG, pixInR};
  assign pixOutR  = pixOutBus[0];
  assign pixOutG  = pixOutBus[1];
  assign pixOutB  = pixOutBus[2];

  csc_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWrEn     (cfgWrEn),
    .cfgAddr     (cfgAddr),
    .cfgModeBits (cfgWrData[1:0]),
    .frameStart  (frameStart),
    .ctl         (ctl),
    .activeMode  (activeMode)
  );

  csc_datapath #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cfgWrData   (cfgWrData),
    .pixInValid  (pixInValid),
    .pixIn       (pixInBus),
    .pixOutValid (pixOutValid),
    .pixOut      (pixOutBus)
  );
endmodule

// File: tb/colour_matrix_pingpong_tb_top.sv
`timescale 1ns/1ps
module colour_matrix_pingpong_tb_top;
  localparam int PW  = 12;
  localparam int MAX = (1 << PW) - 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWrEn = 1'b0, frameStart = 1'b0, pixInValid = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [PW-1:0] pixInR = '0, pixInG = '0, pixInB = '0;
  logic pixOutValid;
  logic [PW-1:0] pixOutR, pixOutG, pixOutB;
  logic [1:0] activeMode;

  int total = 0, bad = 0;
  int modelCoef [2][12];

  always #2.5 clk = ~clk;

  colour_matrix_pingpong dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .frameStart(frameStart), .pixInValid(pixInValid), .pixInR(pixInR), .pixInG(pixInG),
    .pixInB(pixInB), .pixOutValid(pixOutValid), .pixOutR(pixOutR), .pixOutG(pixOutG),
    .pixOutB(pixOutB), .activeMode(activeMode)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int calcOut(input int bank, input int row, input int r, input int g, input int b);
    longint acc;
    acc = longint'(modelCoef[bank][row*4]) * r + longint'(modelCoef[bank][row*4+1]) * g
        + longint'(modelCoef[bank][row*4+2]) * b + (longint'(modelCoef[bank][row*4+3]) <<< 13) + 4096;
    acc = acc >>> 13;
    if (acc < 0) return 0;
    if (acc > MAX) return MAX;
    return int'(acc);
  endfunction

  task automatic cfgWrite(input logic [3:0] a, input logic [31:0] d);
    cfgAddr = a; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic loadBank(input int bank, input int c [12], input bit accepted);
    for (int w = 0; w < 6; w++) begin
      cfgWrite({bank[0], 3'(w)}, {16'(c[2*w+1]), 16'(c[2*w])});
      if (accepted) begin
        modelCoef[bank][2*w]   = c[2*w];
        modelCoef[bank][2*w+1] = c[2*w+1];
      end
    end
  endtask

  task automatic pulseFrame;
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic sendPixel(input int r, input int g, input int b, output int oR, output int oG, output int oB, output int ov);
    pixInR = PW'(r); pixInG = PW'(g); pixInB = PW'(b); pixInValid = 1'b1;
    @(negedge clk);
    pixInValid = 1'b0;
    @(negedge clk);
    oR = pixOutR; oG = pixOutG; oB = pixOutB; ov = pixOutValid;
  endtask

  task automatic checkMatrix(input string tag, input int bank, input int r, input int g, input int b);
    int oR, oG, oB, ov;
    sendPixel(r, g, b, oR, oG, oB, ov);
    check({tag, " valid"}, ov, 1);
    check({tag, " ch1"}, oR, calcOut(bank, 0, r, g, b));
    check({tag, " ch2"}, oG, calcOut(bank, 1, r, g, b));
    check({tag, " ch3"}, oB, calcOut(bank, 2, r, g, b));
  endtask

  task automatic checkBypass(input string tag, input int r, input int g, input int b);
    int oR, oG, oB, ov;
    sendPixel(r, g, b, oR, oG, oB, ov);
    check({tag, " valid"}, ov, 1);
    check({tag, " ch1"}, oR, r);
    check({tag, " ch2"}, oG, g);
    check({tag, " ch3"}, oB, b);
  endtask

  task automatic testReset;
    check("R1 status", activeMode, 0);
    check("R1 valid", pixOutValid, 0);
    check("R1 out", pixOutR + pixOutG + pixOutB, 0);
  endtask

  task automatic testBypass;
    checkBypass("R2 bypass a", 100, 2000, 4095);
    checkBypass("R2 bypass b", 0, 7, 3333);
  endtask

  task automatic testPendingThenCommit;
    int rot [12] = '{0, 8192, 0, 0,  0, 0, 8192, 0,  8192, 0, 0, 0};
    loadBank(0, rot, 1'b1);
    cfgWrite(4'hF, 32'd1);
    check("R6 status before frame", activeMode, 0);
    checkBypass("R6 still bypass before frame", 10, 20, 30);
    pulseFrame();
    check("R3 status set A", activeMode, 1);
    checkMatrix("R3 set A rotation", 0, 10, 20, 30);
  endtask

  task automatic testLiveWriteIgnored;
    int junk [12] = '{-8192, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11};
    loadBank(0, junk, 1'b0);
    checkMatrix("R5 live set A unchanged", 0, 111, 222, 333);
  endtask

  task automatic testSetB;
    int mixB [12] = '{4096, 2048, -1024, 10,  12288, 0, 0, -5,  -8192, 0, 8192, 100};
    loadBank(1, mixB, 1'b1);
    cfgWrite(4'hF, 32'd2);
    check("R6 status held at A", activeMode, 1);
    pulseFrame();
    check("R3 status set B", activeMode, 2);
    checkMatrix("R7 round half a", 1, 1, 0, 0);
    checkMatrix("R7 round half b", 1, 3, 2, 4);
    checkMatrix("R7 mid values", 1, 1234, 567, 890);
    checkMatrix("R8 saturate", 1, 4095, 0, 0);
    check("R8 ch2 hits max", calcOut(1, 1, 4095, 0, 0), MAX);
    check("R8 ch3 hits zero", calcOut(1, 2, 4095, 0, 0), 0);
  endtask

  task automatic testReservedMode;
    cfgWrite(4'hF, 32'd3);
    pulseFrame();
    check("R3 mode 3 discarded", activeMode, 2);
    checkMatrix("R3 set B kept", 1, 50, 60, 70);
  endtask

  task automatic testUnusedWords;
    cfgWrite(4'd6, 32'hFFFF_FFFF);
    cfgWrite(4'd7, 32'h1234_5678);
    cfgWrite(4'hE, 32'hFFFF_FFFF);
    cfgWrite(4'hF, 32'd1);
    pulseFrame();
    check("R4 back to set A", activeMode, 1);
    checkMatrix("R4 words 6/7 store nothing", 0, 9, 99, 999);
  endtask

  task automatic testStream;
    pixInR = 12'd1; pixInG = 12'd2; pixInB = 12'd3; pixInValid = 1'b1;
    @(negedge clk);
    pixInValid = 1'b0;
    @(negedge clk);
    check("R9 first valid", pixOutValid, 1);
    check("R9 first data", pixOutR, calcOut(0, 0, 1, 2, 3));
    pixInR = 12'd40; pixInG = 12'd50; pixInB = 12'd60; pixInValid = 1'b1;
    @(negedge clk);
    check("R9 gap valid low", pixOutValid, 0);
    pixInValid = 1'b0;
    @(negedge clk);
    check("R9 second valid", pixOutValid, 1);
    check("R9 second data", pixOutB, calcOut(0, 2, 40, 50, 60));
  endtask

  task automatic testReturnBypass;
    cfgWrite(4'hF, 32'd0);
    pulseFrame();
    check("R2 status back to 0", activeMode, 0);
    checkBypass("R2 bypass after matrix", 4095, 1, 2048);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int k = 0; k < 12; k++) modelCoef[b][k] = 0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBypass();
    testPendingThenCommit();
    testLiveWriteIgnored();
    testSetB();
    testReservedMode();
    testUnusedWords();
    testStream();
    testReturnBypass();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule